// File: doc/BRIEF.md
# Link Test Pattern Generator

This block produces one 64-bit parallel word per clock for the parallel side of a serial transceiver, as the stimulus for link bit-error-rate and latency runs. A 3-bit mode input selects the pattern while the design is running. There are four maximal-length pseudo-random sequences (register lengths 8, 16, 31 and 32), a zero-run stress word, and a 64-bit incrementing counter. A word is handed over with a valid/ready handshake. A change of mode, or a restart request, is applied only when a word is accepted. The generator that is then selected starts again from its seed, or from zero.

The controller is a small state machine. Each state is the generator that is active: `G_PRN8`, `G_PRN16`, `G_PRN31`, `G_PRN32`, `G_ZRUN` or `G_COUNT`. Reset enters the state that the mode input names. At an accepted word, the transition *reload* moves to the state that the mode input names and reloads the generator. This happens when the requested state differs from the current one, or when restart is high. Otherwise the transition *advance* keeps the state and steps the generator by one word. With no accepted word, the state holds.

Top module: `link_pattern_gen`

## Requirements
- R1: While `rst` is high, `out_valid` is low. From the first clock edge with `rst` low, `out_valid` is high. The first word comes from the mode that `mode_sel` selects during reset.
- R2: While `out_valid` is high and `out_ready` is low, `out_word` and the generator state are held. Changes on `mode_sel`, `seed`, `zrun_len` and `restart` have no effect until a word is accepted.
- R3: The mode codes are 0 for an 8-bit pseudo-random sequence, 1 for 16-bit, 2 for 31-bit, 3 for 32-bit, 4 for zero run and 5 for counter. Codes 6 and 7 also select the counter. A new code takes effect on the word that follows the next accepted word, and that word is the first word of the newly started generator.
- R4: A pseudo-random word holds 64 consecutive bits a[n]..a[n+63] of the sequence, with a[n] in bit 0. Successive words continue the sequence with no gap. The register bits are loaded so that a[i] = state bit i. The recurrence a[k+L] = XOR of a[k+t] is taken over these tap offsets t: L=8 uses {0,2,3,4}, L=16 uses {0,2,3,5}, L=31 uses {0,3}, and L=32 uses {0,10,30,31}.
- R5: On a load, the register takes the low L bits of `seed`. If those bits are all zero, the register is loaded with all ones instead. The register never holds all zeros.
- R6: In zero-run mode, bits 0..N-1 of the word are 0. Bit N is 1, and the bits above it alternate 0,1,0 and so on. N is `zrun_len` limited to 64 (any value above 64 acts as 64). N is sampled in reset and at each accepted word, and it applies to the next word.
- R7: N = 0 gives a word that alternates from bit 0 (bit 0 = 1). N = 64 gives an all-zero word.
- R8: In counter mode, the first word after a load is 0. Each accepted word is followed by the previous value plus one, modulo 2^64.
- R9: When `restart` is high at an accepted word, the current mode is reloaded as in R3, even if the mode code has not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 3 | Pattern mode code (R3) |
| zrun_len | input | 7 | Zero-run length N |
| seed | input | 32 | Pseudo-random seed, low L bits used |
| restart | input | 1 | Reload current generator at next accepted word |
| out_ready | input | 1 | Consumer accepts the word |
| out_valid | output | 1 | Word is valid |
| out_word | output | 64 | Pattern word, bit 0 earliest on the line |

## Verification
The hardest condition to reach from the ports is a mode or input change that arrives while the consumer is stalling. That change must not disturb the word that is being held, and it must take effect only after that word is accepted. The stimulus drives `out_ready` low, changes `mode_sel` and `zrun_len` during the stall, and checks that the word does not move. It then accepts exactly one word and expects the first word of the new generator. A second hard case is the all-zero seed. It is reached with a seed whose low byte is zero but whose upper bits are set, so the stream must start from the all-ones register.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    localparam int WORD_W  = 64;
    localparam int REG_W   = 32;
    localparam int ZRUN_W  = 7;
    localparam int N_LANES = 4;

    typedef enum logic [2:0] {
        G_PRN8  = 3'd0,
        G_PRN16 = 3'd1,
        G_PRN31 = 3'd2,
        G_PRN32 = 3'd3,
        G_ZRUN  = 3'd4,
        G_COUNT = 3'd5
    } gen_e;

    typedef enum logic [1:0] {
        SRC_PRN   = 2'd0,
        SRC_ZRUN  = 2'd1,
        SRC_COUNT = 2'd2
    } src_e;

    localparam int          LANE_LEN [N_LANES] = '{8, 16, 31, 32};
    localparam logic [31:0] LANE_TAP [N_LANES] = '{32'h0000_001D, 32'h0000_002D,
                                                   32'h0000_0009, 32'hC000_0401};

    function automatic gen_e decode_mode(input logic [2:0] code);
        gen_e g;
        unique case (code)
            3'd0:    g = G_PRN8;
            3'd1:    g = G_PRN16;
            3'd2:    g = G_PRN31;
            3'd3:    g = G_PRN32;
            3'd4:    g = G_ZRUN;
            default: g = G_COUNT;
        endcase
        return g;
    endfunction

    function automatic int gen_len(input gen_e g);
        int n;
        unique case (g)
            G_PRN8:  n = 8;
            G_PRN16: n = 16;
            G_PRN31: n = 31;
            default: n = 32;
        endcase
        return n;
    endfunction

    function automatic logic [REG_W-1:0] seed_fix(input logic [REG_W-1:0] s, input int len);
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] v;
        mask = (len >= REG_W) ? '1 : ((REG_W'(1) << len) - REG_W'(1));
        v    = s & mask;
        return (v == '0) ? mask : v;
    endfunction
endpackage

// File: rtl/lpg_lfsr_lane.sv
module lpg_lfsr_lane #(
    parameter int          LEN    = 8,
    parameter logic [31:0] TAPS   = 32'h1D,
    parameter int          WORD_W = 64,
    parameter int          REG_W  = 32
) (
    input  logic [REG_W-1:0]  st_i,
    output logic [WORD_W-1:0] word_o,
    output logic [REG_W-1:0]  st_o
);
    logic [LEN-1:0] s;
    logic           fb;

    // Unrolled: emit the lowest bit, shift in the feedback at the top.
    always_comb begin
        s      = st_i[LEN-1:0];
        word_o = '0;
        fb     = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            word_o[i] = s[0];
            fb        = ^(s & TAPS[LEN-1:0]);
            s         = {fb, s[LEN-1:1]};
        end
        st_o = REG_W'(s);
    end
endmodule

// File: rtl/lpg_lfsr_bank.sv
module lpg_lfsr_bank
    import lpg_pkg::*;
(
    input  logic [REG_W-1:0]                 st_i,
    output logic [N_LANES-1:0][WORD_W-1:0]   words_o,
    output logic [N_LANES-1:0][REG_W-1:0]    nxt_o
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        lpg_lfsr_lane #(
            .LEN    (LANE_LEN[g]),
            .TAPS   (LANE_TAP[g]),
            .WORD_W (WORD_W),
            .REG_W  (REG_W)
        ) u_lane (
            .st_i   (st_i),
            .word_o (words_o[g]),
            .st_o   (nxt_o[g])
        );
    end
endmodule

// File: rtl/lpg_zrun_word.sv
module lpg_zrun_word #(
    parameter int WORD_W = 64,
    parameter int ZRUN_W = 7
) (
    input  logic [ZRUN_W-1:0] n_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [WORD_W-1:0] ALT = {(WORD_W/2){2'b01}};

    // Shifting the alternating word up by N leaves N zeros below a leading one.
    assign word_o = ALT << n_i;
endmodule

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
    import lpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  logic       restart,
    input  logic       advance,
    output gen_e       state_o,
    output logic       reload_o,
    output src_e       src_o,
    output logic [1:0] lane_o
);
    gen_e state_q, state_d, req;

    assign req      = decode_mode(mode_sel);
    assign reload_o = advance && (restart || (req != state_q));
    assign state_o  = state_q;

    always_comb begin
        state_d = state_q;
        if (reload_o) state_d = req;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= req;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            G_PRN8:  begin src_o = SRC_PRN;   lane_o = 2'd0; end
            G_PRN16: begin src_o = SRC_PRN;   lane_o = 2'd1; end
            G_PRN31: begin src_o = SRC_PRN;   lane_o = 2'd2; end
            G_PRN32: begin src_o = SRC_PRN;   lane_o = 2'd3; end
            G_ZRUN:  begin src_o = SRC_ZRUN;  lane_o = 2'd0; end
            default: begin src_o = SRC_COUNT; lane_o = 2'd0; end
        endcase
    end
endmodule

// File: rtl/link_pattern_gen.sv
module link_pattern_gen
    import lpg_pkg::*;
#(
    parameter int P_WORD_W = lpg_pkg::WORD_W,
    parameter int P_REG_W  = lpg_pkg::REG_W,
    parameter int P_ZRUN_W = lpg_pkg::ZRUN_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          mode_sel,
    input  logic [P_ZRUN_W-1:0] zrun_len,
    input  logic [P_REG_W-1:0]  seed,
    input  logic                restart,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [P_WORD_W-1:0] out_word
);
    localparam logic [P_ZRUN_W-1:0] ZMAX = P_ZRUN_W'(P_WORD_W);

    gen_e                gen_state;
    src_e                src;
    logic [1:0]          lane;
    logic                reload, advance, valid_q;
    logic [P_REG_W-1:0]  lfsr_q, load_val;
    logic [P_WORD_W-1:0] cnt_q, zword;
    logic [P_ZRUN_W-1:0] zrun_q, zclamp;
    logic [N_LANES-1:0][P_WORD_W-1:0] lane_word;
    logic [N_LANES-1:0][P_REG_W-1:0]  lane_nxt;

    assign advance   = valid_q && out_ready;
    assign out_valid = valid_q;
    assign zclamp    = (zrun_len > ZMAX) ? ZMAX : zrun_len;
    assign load_val  = seed_fix(seed, gen_len(decode_mode(mode_sel)));

    lpg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .restart  (restart),
        .advance  (advance),
        .state_o  (gen_state),
        .reload_o (reload),
        .src_o    (src),
        .lane_o   (lane)
    );

    lpg_lfsr_bank u_bank (
        .st_i    (lfsr_q),
        .words_o (lane_word),
        .nxt_o   (lane_nxt)
    );

    lpg_zrun_word #(.WORD_W(P_WORD_W), .ZRUN_W(P_ZRUN_W)) u_zrun (
        .n_i    (zrun_q),
        .word_o (zword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            lfsr_q  <= load_val;
            cnt_q   <= '0;
            zrun_q  <= zclamp;
        end else begin
            valid_q <= 1'b1;
            if (advance) begin
                zrun_q <= zclamp;
                if (reload) begin
                    lfsr_q <= load_val;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + P_WORD_W'(1);
                    if (src == SRC_PRN) lfsr_q <= lane_nxt[lane];
                end
            end
        end
    end

    always_comb begin
        unique case (src)
            SRC_PRN:  out_word = lane_word[lane];
            SRC_ZRUN: out_word = zword;
            default:  out_word = cnt_q;
        endcase
    end
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker
    import lpg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input gen_e              gen_state,
    input logic              reload,
    input logic [REG_W-1:0]  lfsr_q,
    input logic [ZRUN_W-1:0] zrun_q
);
    AST_VALID_UP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_word)); // R2

    AST_STATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(gen_state)); // R3

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (lfsr_q != '0)); // R5

    AST_ZRUN_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && gen_state == G_ZRUN) |->
            (((out_word & (out_word >> 1)) == '0) &&
             ($countones(out_word) == (65 - int'(zrun_q)) / 2))); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !reload && gen_state == G_COUNT) |=>
            (out_word == $past(out_word) + WORD_W'(1))); // R8

    AST_RELOAD_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        reload |=> ((gen_state != G_COUNT) || (out_word == '0))); // R9
endmodule

bind link_pattern_gen lpg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .gen_state (gen_state),
    .reload    (reload),
    .lfsr_q    (lfsr_q),
    .zrun_q    (zrun_q)
);

// File: tb/link_pattern_gen_tb.sv
module link_pattern_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode_sel;
    logic [6:0]  zrun_len;
    logic [31:0] seed;
    logic        restart;
    logic        out_ready;
    logic        out_valid;
    logic [63:0] out_word;

    always #10 clk = ~clk;

    link_pattern_gen u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .zrun_len(zrun_len),
        .seed(seed), .restart(restart), .out_ready(out_ready),
        .out_valid(out_valid), .out_word(out_word)
    );

    typedef struct { logic [63:0] w; string tag; } exp_t;
    exp_t q[$];

    int checks = 0;
    int errors = 0;
    string cur_tag = "R4";

    int          b_mode;
    logic [31:0] b_s;
    logic [63:0] b_cnt;
    int          b_zn;

    function automatic int m_len(int m);
        return (m == 0) ? 8 : (m == 1) ? 16 : (m == 2) ? 31 : 32;
    endfunction

    function automatic logic [31:0] m_tap(int m);
        return (m == 0) ? 32'h1D : (m == 1) ? 32'h2D : (m == 2) ? 32'h9 : 32'hC0000401;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_load();
        logic [31:0] mask;
        b_mode = (mode_sel > 3'd5) ? 5 : int'(mode_sel);
        if (b_mode < 4) begin
            mask = (m_len(b_mode) == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_len(b_mode)) - 32'd1);
            b_s  = seed & mask;
            if (b_s == 32'd0) b_s = mask;
        end
        b_cnt = 64'd0;
    endtask

    task automatic model_emit();
        exp_t e;
        logic [63:0] w;
        logic f;
        w = 64'd0;
        if (b_mode < 4) begin
            for (int i = 0; i < 64; i++) begin
                w[i] = b_s[0];
                f    = ^(b_s & m_tap(b_mode));
                b_s  = (b_s >> 1) | (32'(f) << (m_len(b_mode) - 1));
            end
        end else if (b_mode == 4) begin
            for (int i = 0; i < 64; i++)
                w[i] = (i >= b_zn) && (((i - b_zn) % 2) == 0);
        end else begin
            w     = b_cnt;
            b_cnt = b_cnt + 64'd1;
        end
        e.w = w; e.tag = cur_tag;
        q.push_back(e);
    endtask

    task automatic model_step();
        int req;
        req  = (mode_sel > 3'd5) ? 5 : int'(mode_sel);
        b_zn = (zrun_len > 7'd64) ? 64 : int'(zrun_len);
        if (restart || req != b_mode) model_load();
        model_emit();
    endtask

    // Monitor: pops the expected word for every accepted word.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4", out_word, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(out_word === e.w, e.tag, out_word, e.w);
            end
        end
    end

    task automatic cyc(input logic rdy);
        out_ready = rdy;
        @(posedge clk);
        if (rdy) model_step();
        #2;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; mode_sel = 3'd3; seed = 32'h1; zrun_len = 7'd0;
        restart = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);
        b_zn = 0; cur_tag = "R1"; model_load(); model_emit();
        rst = 1'b0;
        cyc(1'b0);
        chk(out_valid === 1'b1, "R1", 64'(out_valid), 64'd1);

        cur_tag = "R4"; run(20);

        // Stall while changing mode and length: word must hold.
        held = out_word;
        mode_sel = 3'd4; zrun_len = 7'd5; seed = 32'h55;
        cyc(1'b0); cyc(1'b0); cyc(1'b0);
        chk(out_word === held, "R2", out_word, held);
        cur_tag = "R3"; cyc(1'b1);
        cur_tag = "R6"; run(3);
        zrun_len = 7'd0;   cur_tag = "R7"; run(2);
        zrun_len = 7'd64;  cur_tag = "R7"; run(2);
        zrun_len = 7'd100; cur_tag = "R6"; run(2);
        zrun_len = 7'd63;  run(2);
        zrun_len = 7'd1;   run(2);

        mode_sel = 3'd5; cur_tag = "R3"; cyc(1'b1);
        cur_tag = "R8"; run(10);
        restart = 1'b1; cur_tag = "R9"; cyc(1'b1);
        restart = 1'b0; cur_tag = "R8"; run(5);

        mode_sel = 3'd0; seed = 32'h0000_1200; cur_tag = "R5"; cyc(1'b1);
        cur_tag = "R4"; run(30);

        mode_sel = 3'd1; seed = 32'h0000_ACE1; cur_tag = "R3"; cyc(1'b1);
        cur_tag = "R4";
        for (int i = 0; i < 40; i++) cyc((i % 3) != 0);

        mode_sel = 3'd2; seed = 32'h8000_0000; cur_tag = "R5"; cyc(1'b1);
        cur_tag = "R4"; run(40);

        restart = 1'b1; seed = 32'h1234_5678; cur_tag = "R9"; cyc(1'b1);
        restart = 1'b0; cur_tag = "R4"; run(10);

        mode_sel = 3'd3; seed = 32'hDEAD_BEEF; cur_tag = "R3"; cyc(1'b1);
        cur_tag = "R4"; run(25);

        mode_sel = 3'd7; cur_tag = "R3"; cyc(1'b1);
        cur_tag = "R8"; run(4);

        out_ready = 1'b0;
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule